// File: doc/BRIEF.md
# Reference Pulse Timestamp Validator

This block stamps each rising edge of a once-per-second reference pulse with the value of a free-running count of local base-oscillator cycles. It then judges whether the interval since the previous stamp is believable for the configured nominal number of base cycles per second. The pulse input is asynchronous. It passes through a synchronizer and an edge detector, and each edge produces one capture. The block reports the capture stamp, a running sequence tag, the interval, a validity flag and a one-cycle strobe. It also reports the averaging gate length that the run of consecutive accepted intervals supports.

The count is split into a low base-clock counter of `CNT_W` bits and a high wrap counter of `EXT_W` bits. Together they form one `W = CNT_W + EXT_W` bit stamp (32 + 16 = 48 by default). The tolerance window is the nominal count plus or minus the nominal divided by `TOL_DIV` (10000 by default, which gives ±100 ppm, or ±5000 counts for a 50 MHz base). Downstream logic can divide stamp differences over the reported gate length. That averaging and the sample history live outside this block. `rst_ni` is asserted asynchronously and is assumed to be released in step with `clk_i`.

Top module: `pps_stamp_check`

## Requirements
- R1: A rising edge on `pulse_i` is sampled by a two-stage synchronizer. The capture happens at the clock edge two edges after the edge that first samples the pulse high. `ready_o` is high for exactly that one cycle. A pulse held high for many cycles gives a single capture.
- R2: `stamp_o` holds the stamp taken at the last capture. The stamp is a W-bit count of base clock edges since reset release, modulo 2^W. Its low `CNT_W` bits are the base counter, and its high `EXT_W` bits count the wraps of that counter.
- R3: The sequence tag `seq_o` (16 bits, modulo 2^16) advances by one on every capture and on every missing-pulse event. It is 0 after reset.
- R4: `delta_o` equals (new stamp − previous stamp) modulo 2^W, so a wrap of the full stamp still gives the true interval. On the first capture after reset it is 0.
- R5: A capture is paired with the previous one only when its tag exceeds the stored tag of the previous capture by exactly 1 (modulo 2^16). Otherwise the capture is rejected.
- R6: `valid_o` is updated on each capture. It is set when the pair is usable and `delta_o` lies in [N − N/TOL_DIV, N + N/TOL_DIV], where N is `nominal_i` and the division is integer. It is cleared otherwise, and on the first capture after reset.
- R7: If no capture occurs for N + N/TOL_DIV + 2 clock edges after the last capture (or after reset, or after the last missing event), a missing event occurs. A missing event clears `valid_o`, zeroes the accepted count and advances the tag.
- R8: The gate output depends on the accepted count. A count of at least 1500 gives `gate_o` = 1000, at least 200 gives 100, at least 20 gives 10, and at least 10 gives 1. Below 10, `gate_o` = 0 and `avg_ok_o` = 0. Otherwise `avg_ok_o` = 1.
- R9: The accepted count rises by one on each valid interval and saturates at 2^ACC_W − 1. It returns to 0 on every rejected paired capture.
- R10: While reset is asserted, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Base oscillator clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pulse_i | input | 1 | Asynchronous once-per-second reference pulse |
| nominal_i | input | NOM_W | Nominal base cycles per pulse interval (held static) |
| stamp_o | output | CNT_W+EXT_W | Stamp of the last capture |
| seq_o | output | SEQ_W | Running sequence tag |
| delta_o | output | CNT_W+EXT_W | Interval to the previous capture |
| valid_o | output | 1 | Last interval accepted |
| ready_o | output | 1 | One-cycle strobe per capture |
| gate_o | output | 10 | Averaging gate length in pulses (0 = none) |
| avg_ok_o | output | 1 | Enough accepted samples for an average |

## Verification
On every cycle, the assertions check these local rules: single-cycle edge strobes, a stamp that advances by exactly one per clock, tag advance on captures and missing events, and `valid_o` rising only at a capture. They also check that a rejection or missing event clears the accepted count and that the count saturates. Other behaviours only show up in the bench's scenarios against its behavioural model. These are the exact window edges (accepted at ±tolerance, rejected one count beyond), the loss of validity after a pulse gap and the recovery that follows, the gate tiers climbing as hundreds of intervals accumulate, saturation without wrap, and intervals that straddle a wrap of the full stamp.

// File: rtl/pps_pkg.sv
package pps_pkg;
  // averaging gate tiers, highest first: minimum accepted count and gate length
  localparam int unsigned GATE_W = 10;
  localparam int unsigned N_TIER = 4;
  localparam logic [15:0] TIER_MIN [N_TIER] = '{16'd1500, 16'd200, 16'd20, 16'd10};
  localparam logic [GATE_W-1:0] TIER_GATE [N_TIER] = '{10'd1000, 10'd100, 10'd10, 10'd1};
endpackage

// File: rtl/pps_edge_sync.sv
module pps_edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic rise_o
);
  logic [STAGES-1:0] pipe_q, pipe_d;
  logic              last_q, last_d;

  always_comb begin
    pipe_d = {pipe_q[STAGES-2:0], async_i};
    last_d = pipe_q[STAGES-1];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pipe_q <= '0;
      last_q <= 1'b0;
    end else begin
      pipe_q <= pipe_d;
      last_q <= last_d;
    end
  end

  assign rise_o = pipe_q[STAGES-1] & ~last_q;

  // R1: an edge strobe never lasts two cycles
  p_rise_single_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o);
endmodule

// File: rtl/pps_timebase.sv
module pps_timebase #(
  parameter int unsigned CNT_W = 32,
  parameter int unsigned EXT_W = 16,
  localparam int unsigned W = CNT_W + EXT_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  output logic [W-1:0] now_o
);
  logic [CNT_W-1:0] base_q, base_d;
  logic [EXT_W-1:0] wrap_q, wrap_d;
  logic             at_top;

  always_comb begin
    at_top = &base_q;
    base_d = base_q + CNT_W'(1);
    wrap_d = at_top ? wrap_q + EXT_W'(1) : wrap_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q <= '0;
      wrap_q <= '0;
    end else begin
      base_q <= base_d;
      wrap_q <= wrap_d;
    end
  end

  assign now_o = {wrap_q, base_q};

  // R2: the combined stamp advances by exactly one per base clock
  p_stamp_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> now_o == $past(now_o) + W'(1));
endmodule

// File: rtl/pps_miss_watch.sv
module pps_miss_watch #(
  parameter int unsigned LIM_W = 33
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             capture_i,
  input  logic [LIM_W-1:0] limit_i,
  output logic             miss_o
);
  logic [LIM_W-1:0] gap_q, gap_d;

  always_comb begin
    miss_o = ~capture_i & (gap_q == limit_i);
    if (capture_i || miss_o) gap_d = '0;
    else                     gap_d = gap_q + LIM_W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) gap_q <= '0;
    else         gap_q <= gap_d;
  end

  // R7: a missing event restarts the gap, so two never come back to back
  p_miss_spaced_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    miss_o |=> !miss_o);
endmodule

// File: rtl/pps_interval_judge.sv
module pps_interval_judge #(
  parameter int unsigned W       = 48,
  parameter int unsigned NOM_W   = 32,
  parameter int unsigned SEQ_W   = 16,
  parameter int unsigned TOL_DIV = 10000,
  localparam int unsigned LIM_W  = NOM_W + 1,
  localparam int unsigned CMP_W  = (W > LIM_W) ? W : LIM_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             capture_i,
  input  logic             miss_i,
  input  logic [W-1:0]     now_i,
  input  logic [NOM_W-1:0] nominal_i,
  output logic [W-1:0]     stamp_o,
  output logic [SEQ_W-1:0] seq_o,
  output logic [W-1:0]     delta_o,
  output logic             valid_o,
  output logic             ready_o,
  output logic             accept_o,
  output logic             reject_o,
  output logic [LIM_W-1:0] limit_o
);
  logic [NOM_W-1:0] tol_q, tol_d;
  logic [W-1:0]     stamp_q, stamp_d, delta_q, delta_d, prev_q, prev_d;
  logic [SEQ_W-1:0] seq_q, seq_d, ptag_q, ptag_d;
  logic             have_q, have_d, valid_q, valid_d, ready_q, ready_d;

  logic [SEQ_W-1:0] seq_next, tag_step;
  logic [W-1:0]     span;
  logic [CMP_W-1:0] span_x, win_lo, win_hi;
  logic             in_win, pair_ok, good;

  // window and pairing decision for a capture in this cycle
  always_comb begin
    seq_next = seq_q + SEQ_W'(1);
    tag_step = seq_next - ptag_q;
    span     = now_i - prev_q;
    span_x   = CMP_W'(span);
    win_lo   = CMP_W'(nominal_i) - CMP_W'(tol_q);
    win_hi   = CMP_W'(nominal_i) + CMP_W'(tol_q);
    in_win   = (span_x >= win_lo) && (span_x <= win_hi);
    pair_ok  = have_q && (tag_step == SEQ_W'(1));
    good     = pair_ok && in_win;
    accept_o = capture_i && good;
    reject_o = capture_i && have_q && !good;
    limit_o  = LIM_W'(nominal_i) + LIM_W'(tol_q) + LIM_W'(1);
  end

  // next state
  always_comb begin
    tol_d   = nominal_i / NOM_W'(TOL_DIV);
    stamp_d = stamp_q;
    delta_d = delta_q;
    prev_d  = prev_q;
    seq_d   = seq_q;
    ptag_d  = ptag_q;
    have_d  = have_q;
    valid_d = valid_q;
    ready_d = 1'b0;
    if (capture_i) begin
      stamp_d = now_i;
      delta_d = have_q ? span : '0;
      valid_d = good;
      prev_d  = now_i;
      seq_d   = seq_next;
      ptag_d  = seq_next;
      have_d  = 1'b1;
      ready_d = 1'b1;
    end else if (miss_i) begin
      seq_d   = seq_next;
      valid_d = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tol_q   <= '0;
      stamp_q <= '0;
      delta_q <= '0;
      prev_q  <= '0;
      seq_q   <= '0;
      ptag_q  <= '0;
      have_q  <= 1'b0;
      valid_q <= 1'b0;
      ready_q <= 1'b0;
    end else begin
      tol_q   <= tol_d;
      stamp_q <= stamp_d;
      delta_q <= delta_d;
      prev_q  <= prev_d;
      seq_q   <= seq_d;
      ptag_q  <= ptag_d;
      have_q  <= have_d;
      valid_q <= valid_d;
      ready_q <= ready_d;
    end
  end

  assign stamp_o = stamp_q;
  assign delta_o = delta_q;
  assign seq_o   = seq_q;
  assign valid_o = valid_q;
  assign ready_o = ready_q;

  // R3: tag advances on each capture or missing event
  p_seq_adv_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (capture_i || miss_i) |=> seq_o == $past(seq_o) + SEQ_W'(1));
  // R6: validity can only appear as the result of a capture
  p_valid_from_cap_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(valid_o) |-> $past(capture_i));
  // R7: a missing event drops validity
  p_miss_drops_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    miss_i |=> !valid_o);
  // R4: the first capture carries no interval
  p_first_delta_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (capture_i && !have_q) |=> (delta_o == '0) && !valid_o);
endmodule

// File: rtl/pps_gate_sel.sv
module pps_gate_sel import pps_pkg::*; #(
  parameter int unsigned ACC_W = 16,
  localparam int unsigned CW   = (ACC_W > 16) ? ACC_W : 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              accept_i,
  input  logic              clear_i,
  output logic [GATE_W-1:0] gate_o,
  output logic              avg_ok_o
);
  logic [ACC_W-1:0]  acc_q, acc_d;
  logic              acc_full;
  logic [N_TIER-1:0] tier_hit;

  always_comb begin
    acc_full = &acc_q;
    acc_d    = acc_q;
    if (clear_i)                     acc_d = '0;
    else if (accept_i && !acc_full)  acc_d = acc_q + ACC_W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) acc_q <= '0;
    else         acc_q <= acc_d;
  end

  for (genvar t = 0; t < N_TIER; t++) begin : g_tier
    assign tier_hit[t] = CW'(acc_q) >= CW'(TIER_MIN[t]);
  end

  // lowest index is the longest gate and wins
  always_comb begin
    gate_o = '0;
    for (int t = N_TIER - 1; t >= 0; t--) begin
      if (tier_hit[t]) gate_o = TIER_GATE[t];
    end
  end

  assign avg_ok_o = |tier_hit;

  // R9: a rejection or missing event empties the count
  p_clear_acc_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> acc_q == '0);
  // R9: the count saturates rather than wrapping
  p_acc_sat_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_full && !clear_i) |=> acc_full);
  // R8: no gate is reported below the lowest tier
  p_gate_low_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (CW'(acc_q) < CW'(TIER_MIN[N_TIER-1])) |-> (!avg_ok_o && gate_o == '0));
endmodule

// File: rtl/pps_stamp_check.sv
module pps_stamp_check import pps_pkg::*; #(
  parameter int unsigned CNT_W   = 32,
  parameter int unsigned EXT_W   = 16,
  parameter int unsigned NOM_W   = 32,
  parameter int unsigned SEQ_W   = 16,
  parameter int unsigned ACC_W   = 16,
  parameter int unsigned TOL_DIV = 10000,
  parameter int unsigned SYNC_N  = 2,
  localparam int unsigned W      = CNT_W + EXT_W,
  localparam int unsigned LIM_W  = NOM_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pulse_i,
  input  logic [NOM_W-1:0]  nominal_i,
  output logic [W-1:0]      stamp_o,
  output logic [SEQ_W-1:0]  seq_o,
  output logic [W-1:0]      delta_o,
  output logic              valid_o,
  output logic              ready_o,
  output logic [GATE_W-1:0] gate_o,
  output logic              avg_ok_o
);
  logic             capture, miss, accept, reject;
  logic [W-1:0]     now;
  logic [LIM_W-1:0] limit;

  pps_edge_sync #(.STAGES(SYNC_N)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .async_i(pulse_i), .rise_o(capture));

  pps_timebase #(.CNT_W(CNT_W), .EXT_W(EXT_W)) u_tbase (
    .clk_i(clk_i), .rst_ni(rst_ni), .now_o(now));

  pps_miss_watch #(.LIM_W(LIM_W)) u_watch (
    .clk_i(clk_i), .rst_ni(rst_ni), .capture_i(capture),
    .limit_i(limit), .miss_o(miss));

  pps_interval_judge #(.W(W), .NOM_W(NOM_W), .SEQ_W(SEQ_W), .TOL_DIV(TOL_DIV)) u_judge (
    .clk_i(clk_i), .rst_ni(rst_ni), .capture_i(capture), .miss_i(miss),
    .now_i(now), .nominal_i(nominal_i), .stamp_o(stamp_o), .seq_o(seq_o),
    .delta_o(delta_o), .valid_o(valid_o), .ready_o(ready_o),
    .accept_o(accept), .reject_o(reject), .limit_o(limit));

  pps_gate_sel #(.ACC_W(ACC_W)) u_gate (
    .clk_i(clk_i), .rst_ni(rst_ni), .accept_i(accept),
    .clear_i(reject | miss), .gate_o(gate_o), .avg_ok_o(avg_ok_o));

  // R1: capture strobes are isolated single cycles
  p_ready_pulse_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |=> !ready_o);
endmodule

// File: tb/tb_pps_stamp_check.sv
module tb_pps_stamp_check;
  localparam int unsigned CNT_W = 8, EXT_W = 4, W = CNT_W + EXT_W;
  localparam int unsigned ACC_W = 11, TOL_DIV = 10;
  localparam int NOM = 40;
  localparam int TOL = NOM / TOL_DIV;
  localparam int LO = NOM - TOL, HI = NOM + TOL, LIMIT = NOM + TOL + 1;
  localparam int ACC_MAX = (1 << ACC_W) - 1;

  logic clk = 1'b0, rst_n = 1'b0, pulse_i = 1'b0;
  logic [31:0] nominal = 32'(NOM);
  logic [W-1:0] stamp_o, delta_o;
  logic [15:0] seq_o;
  logic valid_o, ready_o, avg_ok_o;
  logic [9:0] gate_o;

  pps_stamp_check #(.CNT_W(CNT_W), .EXT_W(EXT_W), .ACC_W(ACC_W), .TOL_DIV(TOL_DIV)) dut (
    .clk_i(clk), .rst_ni(rst_n), .pulse_i(pulse_i), .nominal_i(nominal),
    .stamp_o(stamp_o), .seq_o(seq_o), .delta_o(delta_o), .valid_o(valid_o),
    .ready_o(ready_o), .gate_o(gate_o), .avg_ok_o(avg_ok_o));

  always #4 clk = ~clk;

  int compared = 0, mismatched = 0;
  bit done = 1'b0, chk_en = 1'b0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference model
  bit [W-1:0] m_tick, m_prev, e_stamp, e_delta, m_d;
  bit [15:0] m_seq, m_ptag, e_seq, m_ns;
  bit m_have, e_valid, e_ready, m_s1, m_s2, m_s3, m_cap, m_good;
  int m_gap, m_acc;

  function automatic int gate_of(input int a);
    if (a >= 1500) return 1000;
    if (a >= 200) return 100;
    if (a >= 20) return 10;
    if (a >= 10) return 1;
    return 0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_tick = '0; m_prev = '0; e_stamp = '0; e_delta = '0;
      m_seq = '0; m_ptag = '0; m_have = 0; e_valid = 0; e_ready = 0;
      m_s1 = 0; m_s2 = 0; m_s3 = 0; m_gap = 0; m_acc = 0;
    end else begin
      m_cap = m_s2 && !m_s3;
      if (m_cap) begin
        m_ns = m_seq + 16'd1;
        m_d = m_tick - m_prev;
        m_good = m_have && (16'(m_ns - m_ptag) == 16'd1) &&
                 (int'(m_d) >= LO) && (int'(m_d) <= HI);
        e_delta = m_have ? m_d : '0;
        e_valid = m_good;
        e_stamp = m_tick;
        if (m_good) begin
          if (m_acc < ACC_MAX) m_acc++;
        end else if (m_have) m_acc = 0;
        m_prev = m_tick; m_ptag = m_ns; m_have = 1; m_seq = m_ns;
        e_ready = 1; m_gap = 0;
      end else begin
        e_ready = 0;
        if (m_gap == LIMIT) begin
          e_valid = 0; m_acc = 0; m_seq = m_seq + 16'd1; m_gap = 0;
        end else m_gap++;
      end
      m_tick = m_tick + W'(1);
      m_s3 = m_s2; m_s2 = m_s1; m_s1 = pulse_i;
    end
  end

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (chk_en && !done) begin
      chk(ready_o == e_ready, "R1 ready", ready_o, e_ready);
      chk(stamp_o == e_stamp, "R2 stamp", stamp_o, e_stamp);
      chk(seq_o == m_seq, "R3 seq", seq_o, m_seq);
      chk(delta_o == e_delta, "R4 delta", delta_o, e_delta);
      chk(valid_o == e_valid, "R6 valid", valid_o, e_valid);
      chk(gate_o == 10'(gate_of(m_acc)), "R8 gate", gate_o, gate_of(m_acc));
      chk(avg_ok_o == (m_acc >= 10), "R8 avg_ok", avg_ok_o, m_acc >= 10);
    end
  end

  task automatic send(input int gap, input int width);
    for (int i = 0; i < gap; i++) begin
      @(negedge clk);
      pulse_i = (i < width);
    end
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      compared++; mismatched++;
      $display("FAIL watchdog R1 actual=hung expected=complete");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10: reset state
    chk(stamp_o == '0 && delta_o == '0 && seq_o == '0, "R10 reset data", stamp_o, 0);
    chk(!valid_o && !ready_o && gate_o == '0 && !avg_ok_o, "R10 reset flags", valid_o, 0);
    rst_n = 1'b1;
    chk_en = 1'b1;

    // steady pulses: gate 1 after ten accepted intervals
    for (int k = 0; k < 12; k++) send(40, 3);
    chk(gate_o == 10'd1 && avg_ok_o, "R8 gate after 11", gate_o, 1);

    // window edges: 44 and 36 accepted
    send(44, 3); send(36, 3); send(40, 3);
    chk(valid_o && delta_o == W'(36), "R6 lower edge", delta_o, 36);
    // 45 rejected, accepted count cleared
    send(45, 3); send(40, 3);
    chk(!valid_o && delta_o == W'(45), "R6 above window", delta_o, 45);
    chk(!avg_ok_o && gate_o == '0, "R9 clear on reject", gate_o, 0);
    send(35, 3); send(40, 3);
    chk(!valid_o && delta_o == W'(35), "R6 below window", delta_o, 35);

    // long held pulse yields one capture per edge
    for (int k = 0; k < 4; k++) send(40, 30);
    chk(valid_o && delta_o == W'(40), "R1 held pulse", delta_o, 40);

    // missing pulse gap
    for (int k = 0; k < 5; k++) send(40, 3);
    send(200, 3);
    chk(!valid_o, "R7 missing drops valid", valid_o, 0);
    send(40, 3);
    chk(!valid_o, "R5 tag gap rejects", valid_o, 0);
    send(40, 3);
    chk(valid_o, "R5 consecutive tags accepted", valid_o, 1);

    // long run: gate tiers, stamp wraps, saturation
    for (int k = 0; k < 2100; k++) begin
      send((k % 2) ? 42 : 38, 3);
      if (k == 30) chk(gate_o == 10'd10, "R8 gate tier 10", gate_o, 10);
      if (k == 250) chk(gate_o == 10'd100, "R8 gate tier 100", gate_o, 100);
    end
    chk(gate_o == 10'd1000 && avg_ok_o, "R9 saturated count keeps gate", gate_o, 1000);
    finish_run();
  end
endmodule